// File: doc/BRIEF.md
# Processor bus cycle command controller

This block turns the status code a processor puts out at the start of each bus transfer into the strobes the rest of the system needs. These are a read or write command for memory, a read or write command for I/O space, an interrupt-acknowledge command, an address-latch pulse, a data-enable signal and a data-direction signal. Every input is sampled, and every output changes, on the falling edge of a clock that runs at twice the processor's internal rate.

Each transfer passes through three phases. The first is a status phase, in which the address-latch pulse is given. Next comes a command phase, which the command-delay input can hold off and which lasts until the active-low ready input ends it. The controller then returns to idle. A per-cycle select input is captured at the end of the status phase, so that several controllers can share one processor and each can claim only its own cycles. A strap input picks between two timing modes. In bus-compatible mode at least one wait state is needed, and the shared enable pin acts as an active-low address enable that also drives the command output-enable flag. In short-cycle mode a zero-wait end is allowed, and the same pin acts as an active-high command gate.

Top module: `bus_cmd_ctrl`

## Requirements
- R1: While reset is high and after it is released, all five commands are high (inactive), and ale, den and dt_r are low. The controller is idle, and the next non-idle status starts a fresh cycle.
- R2: A falling clock edge that samples st_n != 2'b11 while idle starts a cycle. ale is high for exactly the one clock that follows, and no command is active during it.
- R3: The status is decoded as {mem_sel, st_n[1], st_n[0]}: 000 interrupt acknowledge (inta_n), 001 I/O read (iord_n), 010 I/O write (iowr_n), 101 memory read (mrd_n) and 110 memory write (mwr_n). Only that one command goes low, and only during the command phase.
- R4: dt_r is high during the command phase of a write cycle (code 010 or 110) and low at all other times. den is high during the command phase of any cycle whose code carries a command.
- R5: lat_en is sampled at the edge that leaves the status phase. If it is low, the cycle drives no command, no den and no dt_r, and it still ends on ready.
- R6: Each falling edge that samples hold_cmd high keeps the command inactive. The first edge that samples it low, whether at the end of the status phase or later, activates the command.
- R7: ready low (rdy_n = 0) sampled before the command has become active ends the cycle, and no command is ever driven in it.
- R8: With strap_bus low, rdy_n low at the first command-phase edge ends the cycle at that edge (zero wait states).
- R9: With strap_bus high, rdy_n low at the first command-phase edge is ignored. The cycle ends on the first later edge that samples it low.
- R10: With strap_bus high, gate_en high drives cmd_oe low, holds all commands high and holds den low. gate_en low drives cmd_oe high.
- R11: With strap_bus low, cmd_oe stays high. gate_en low holds every command high and den low, and the cycle still ends on ready.
- R12: A halt/shutdown status (100) runs a full cycle with ale but drives no command and no den, and it ends on ready.
- R13: Idle status codes (011 and 111) start no cycle: ale stays low and no command is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock; falling edge samples and updates |
| rst | input | 1 | Asynchronous active-high reset to idle |
| st_n | input | 2 | Active-low bus status, bit 1 and bit 0 |
| mem_sel | input | 1 | High = memory space, low = I/O space |
| strap_bus | input | 1 | Mode strap: high = bus-compatible timing, low = short-cycle timing |
| lat_en | input | 1 | Per-cycle controller select, captured at end of status phase |
| hold_cmd | input | 1 | Command delay, active high, resampled every clock |
| rdy_n | input | 1 | Active-low end-of-cycle |
| gate_en | input | 1 | Address enable (active low, bus mode) or command gate (active high, short mode) |
| mrd_n | output | 1 | Memory read command, active low |
| mwr_n | output | 1 | Memory write command, active low |
| iord_n | output | 1 | I/O read command, active low |
| iowr_n | output | 1 | I/O write command, active low |
| inta_n | output | 1 | Interrupt acknowledge command, active low |
| cmd_oe | output | 1 | Command output enable (low = commands in the off state) |
| ale | output | 1 | Address-latch pulse |
| den | output | 1 | Data transceiver enable |
| dt_r | output | 1 | Data direction: high = transmit, low = receive |

## Verification
Some rules hold on every cycle, and the in-line assertions check those. At most one command is active at a time. A command is never active while the output enable is off, or while ale is high, or without den. The status phase always lasts exactly one clock and is followed by the command phase. In bus-compatible mode a cycle never ends on its first command clock, and idle status codes keep the controller idle.

Other behaviour depends on a sequence of inputs over several clocks, and only the directed scenarios show it. These are the exact decode of each status code, the clock on which a delayed command first appears, early termination with no command, the latched select dropping a whole cycle, and how the shared enable pin behaves in each mode.

// File: rtl/bcc_pkg.sv
package bcc_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_STAT = 2'd1,
    PH_CMD  = 2'd2
  } phase_t;

  localparam int CMD_N  = 5;
  localparam int C_INTA = 0;
  localparam int C_IORD = 1;
  localparam int C_IOWR = 2;
  localparam int C_MRD  = 3;
  localparam int C_MWR  = 4;

  // any status other than both-high requests a cycle
  function automatic logic cyc_request(input logic [1:0] st_n);
    return st_n != 2'b11;
  endfunction

  // {mem_sel, s1, s0} to a one-hot active-high command vector
  function automatic logic [CMD_N-1:0] cmd_of(input logic [2:0] code);
    logic [CMD_N-1:0] v;
    v = '0;
    case (code)
      3'b000:  v[C_INTA] = 1'b1;
      3'b001:  v[C_IORD] = 1'b1;
      3'b010:  v[C_IOWR] = 1'b1;
      3'b101:  v[C_MRD]  = 1'b1;
      3'b110:  v[C_MWR]  = 1'b1;
      default: v = '0;
    endcase
    return v;
  endfunction

  function automatic logic is_write(input logic [2:0] code);
    return code[1:0] == 2'b10;
  endfunction

  function automatic logic moves_data(input logic [2:0] code);
    return |cmd_of(code);
  endfunction

endpackage

// File: rtl/bcc_seq.sv
module bcc_seq
  import bcc_pkg::*;
#(
  parameter int MIN_WAITS = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   st_n,
  input  logic         mem_sel,
  input  logic         strap_bus,
  input  logic         lat_en,
  input  logic         hold_cmd,
  input  logic         rdy_n,
  output phase_t       phase,
  output logic [2:0]   code,
  output logic         sel,
  output logic         go,
  output logic         cyc_start,
  output logic         cyc_end
);

  localparam int WCNT_W = $clog2(MIN_WAITS + 2);

  logic [WCNT_W-1:0] wcnt;
  logic              waited;

  assign waited    = int'(wcnt) >= MIN_WAITS;
  assign cyc_start = (phase == PH_IDLE) && cyc_request(st_n);
  assign cyc_end   = (phase == PH_CMD) && !rdy_n && (!strap_bus || waited);

  always_ff @(negedge clk or posedge rst) begin
    if (rst) begin
      phase <= PH_IDLE;
      code  <= 3'b011;
      sel   <= 1'b0;
      go    <= 1'b0;
      wcnt  <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (cyc_start) begin
            phase <= PH_STAT;
            code  <= {mem_sel, st_n};
          end
        end
        PH_STAT: begin
          phase <= PH_CMD;
          sel   <= lat_en;
          go    <= !hold_cmd;
          wcnt  <= '0;
        end
        PH_CMD: begin
          if (cyc_end) begin
            phase <= PH_IDLE;
            go    <= 1'b0;
          end else begin
            go <= go | !hold_cmd;
            if (int'(wcnt) < MIN_WAITS) wcnt <= wcnt + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R2
  stat_once_chk: assert property (@(negedge clk) disable iff (rst)
    (phase == PH_STAT) |=> (phase == PH_CMD));

  // R9
  bus_wait_chk: assert property (@(negedge clk) disable iff (rst)
    (cyc_end && strap_bus) |-> ($past(phase) == PH_CMD));

  // R13
  idle_stay_chk: assert property (@(negedge clk) disable iff (rst)
    (phase == PH_IDLE && st_n == 2'b11) |=> (phase == PH_IDLE));

endmodule

// File: rtl/bcc_drive.sv
module bcc_drive
  import bcc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  phase_t           phase,
  input  logic [2:0]       code,
  input  logic             sel,
  input  logic             go,
  input  logic             strap_bus,
  input  logic             gate_en,
  output logic [CMD_N-1:0] cmd_n,
  output logic             cmd_oe,
  output logic             ale,
  output logic             den,
  output logic             dt_r
);

  logic             en_ok;
  logic             in_cmd;
  logic [CMD_N-1:0] cmd_act;

  assign en_ok   = strap_bus ? !gate_en : gate_en;
  assign cmd_oe  = strap_bus ? !gate_en : 1'b1;
  assign in_cmd  = (phase == PH_CMD) && sel;
  assign cmd_act = (in_cmd && go && en_ok) ? cmd_of(code) : '0;
  assign cmd_n   = ~cmd_act;
  assign den     = in_cmd && en_ok && moves_data(code);
  assign dt_r    = in_cmd && is_write(code);
  assign ale     = (phase == PH_STAT);

  // R3
  cmd_onehot_chk: assert property (@(negedge clk) disable iff (rst)
    $onehot0(~cmd_n));

  // R10
  off_state_chk: assert property (@(negedge clk) disable iff (rst)
    !cmd_oe |-> (&cmd_n && !den));

  // R4
  cmd_den_chk: assert property (@(negedge clk) disable iff (rst)
    !(&cmd_n) |-> den);

  // R2
  ale_quiet_chk: assert property (@(negedge clk) disable iff (rst)
    ale |-> (&cmd_n && !den && !dt_r));

endmodule

// File: rtl/bus_cmd_ctrl.sv
module bus_cmd_ctrl
  import bcc_pkg::*;
#(
  parameter int MIN_WAITS = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] st_n,
  input  logic       mem_sel,
  input  logic       strap_bus,
  input  logic       lat_en,
  input  logic       hold_cmd,
  input  logic       rdy_n,
  input  logic       gate_en,
  output logic       mrd_n,
  output logic       mwr_n,
  output logic       iord_n,
  output logic       iowr_n,
  output logic       inta_n,
  output logic       cmd_oe,
  output logic       ale,
  output logic       den,
  output logic       dt_r
);

  phase_t           phase;
  logic [2:0]       code;
  logic             sel;
  logic             go;
  logic             cyc_start;
  logic             cyc_end;
  logic [CMD_N-1:0] cmd_n;

  bcc_seq #(.MIN_WAITS(MIN_WAITS)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .st_n      (st_n),
    .mem_sel   (mem_sel),
    .strap_bus (strap_bus),
    .lat_en    (lat_en),
    .hold_cmd  (hold_cmd),
    .rdy_n     (rdy_n),
    .phase     (phase),
    .code      (code),
    .sel       (sel),
    .go        (go),
    .cyc_start (cyc_start),
    .cyc_end   (cyc_end)
  );

  bcc_drive u_drive (
    .clk       (clk),
    .rst       (rst),
    .phase     (phase),
    .code      (code),
    .sel       (sel),
    .go        (go),
    .strap_bus (strap_bus),
    .gate_en   (gate_en),
    .cmd_n     (cmd_n),
    .cmd_oe    (cmd_oe),
    .ale       (ale),
    .den       (den),
    .dt_r      (dt_r)
  );

  assign inta_n = cmd_n[C_INTA];
  assign iord_n = cmd_n[C_IORD];
  assign iowr_n = cmd_n[C_IOWR];
  assign mrd_n  = cmd_n[C_MRD];
  assign mwr_n  = cmd_n[C_MWR];

  // R2
  start_ale_chk: assert property (@(negedge clk) disable iff (rst)
    cyc_start |=> ale);

  // R7
  end_idle_chk: assert property (@(negedge clk) disable iff (rst)
    cyc_end |=> (!ale && !den && !dt_r && mrd_n && mwr_n && iord_n && iowr_n && inta_n));

endmodule

// File: tb/bus_cmd_ctrl_test.sv
`timescale 1ns/1ps
module bus_cmd_ctrl_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] st_n = 2'b11;
  logic       mem_sel = 1'b0;
  logic       strap_bus = 1'b0;
  logic       lat_en = 1'b1;
  logic       hold_cmd = 1'b0;
  logic       rdy_n = 1'b0;
  logic       gate_en = 1'b1;
  logic       mrd_n, mwr_n, iord_n, iowr_n, inta_n, cmd_oe, ale, den, dt_r;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #2.5 clk = ~clk;

  bus_cmd_ctrl uut (
    .clk(clk), .rst(rst), .st_n(st_n), .mem_sel(mem_sel), .strap_bus(strap_bus),
    .lat_en(lat_en), .hold_cmd(hold_cmd), .rdy_n(rdy_n), .gate_en(gate_en),
    .mrd_n(mrd_n), .mwr_n(mwr_n), .iord_n(iord_n), .iowr_n(iowr_n), .inta_n(inta_n),
    .cmd_oe(cmd_oe), .ale(ale), .den(den), .dt_r(dt_r)
  );

  // bench view: {inta, iord, iowr, mrd, mwr} active high
  function automatic logic [4:0] want_cmd(input logic [2:0] c);
    if (c == 3'b000) return 5'b10000;
    if (c == 3'b001) return 5'b01000;
    if (c == 3'b010) return 5'b00100;
    if (c == 3'b101) return 5'b00010;
    if (c == 3'b110) return 5'b00001;
    return 5'b00000;
  endfunction

  // vector {cmds[4:0], den, dt_r, ale, cmd_oe}; ph 0 idle, 1 status, 2 command
  function automatic logic [8:0] want_vec(input int ph, input logic [2:0] c, input bit lat,
                                          input bit go, input bit strap, input bit gate);
    logic oe, en, wr;
    logic [4:0] cm;
    oe = strap ? !gate : 1'b1;
    en = strap ? !gate : gate;
    wr = (c == 3'b010) || (c == 3'b110);
    if (ph == 1) return {5'b0, 1'b0, 1'b0, 1'b1, oe};
    if (ph == 2) begin
      cm = (lat && go && en) ? want_cmd(c) : 5'b0;
      return {cm, lat && en && (want_cmd(c) != 0), lat && wr, 1'b0, oe};
    end
    return {5'b0, 1'b0, 1'b0, 1'b0, oe};
  endfunction

  function automatic logic [8:0] got_vec();
    return {~inta_n, ~iord_n, ~iowr_n, ~mrd_n, ~mwr_n, den, dt_r, ale, cmd_oe};
  endfunction

  task automatic check(input string req, input logic [8:0] exp);
    n_chk++;
    if (got_vec() !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: got %b expected %b", req, $time, got_vec(), exp);
    end
  endtask

  // one complete bus cycle; outputs sampled at rising edges, between falling edges
  task automatic run_cycle(input string req, input bit strap, input bit gate, input logic [2:0] c,
                           input bit lat, input int hold_n, input int ready_at);
    int k_end;
    strap_bus = strap;
    gate_en   = gate;
    @(posedge clk);
    mem_sel  = c[2];
    st_n     = c[1:0];
    rdy_n    = 1'b1;
    hold_cmd = (hold_n > 0);
    lat_en   = lat;
    @(posedge clk);
    check(req, want_vec(1, c, lat, 1'b0, strap, gate));
    st_n = 2'b11;
    k_end = strap ? ((ready_at < 1) ? 1 : ready_at) : ready_at;
    for (int k = 0; k <= k_end; k++) begin
      @(posedge clk);
      check(req, want_vec(2, c, lat, k >= hold_n, strap, gate));
      hold_cmd = (k + 1 < hold_n);
      rdy_n    = !(k >= ready_at);
    end
    @(posedge clk);
    check(req, want_vec(0, c, lat, 1'b0, strap, gate));
    rdy_n    = 1'b1;
    hold_cmd = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    check("R1", want_vec(0, 3'b011, 1'b0, 1'b0, 1'b0, 1'b1));
    rst   = 1'b0;
    rdy_n = 1'b1;
    @(posedge clk);
    check("R1", want_vec(0, 3'b011, 1'b0, 1'b0, 1'b0, 1'b1));
  endtask

  task automatic t_decode_all();
    run_cycle("R3", 1'b0, 1'b1, 3'b000, 1'b1, 0, 0);
    run_cycle("R3", 1'b0, 1'b1, 3'b001, 1'b1, 0, 0);
    run_cycle("R4", 1'b0, 1'b1, 3'b010, 1'b1, 0, 0);
    run_cycle("R3", 1'b0, 1'b1, 3'b101, 1'b1, 0, 1);
    run_cycle("R4", 1'b0, 1'b1, 3'b110, 1'b1, 0, 2);
  endtask

  task automatic t_halt();
    run_cycle("R12", 1'b0, 1'b1, 3'b100, 1'b1, 0, 2);
  endtask

  task automatic t_idle_codes();
    @(posedge clk);
    for (int m = 0; m < 2; m++) begin
      mem_sel = m[0];
      st_n    = 2'b11;
      repeat (3) begin
        @(posedge clk);
        check("R13", want_vec(0, 3'b011, 1'b1, 1'b0, 1'b0, 1'b1));
      end
    end
  endtask

  task automatic t_latched_sel();
    run_cycle("R5", 1'b0, 1'b1, 3'b110, 1'b0, 0, 1);
    run_cycle("R5", 1'b0, 1'b1, 3'b101, 1'b1, 0, 0);
  endtask

  task automatic t_cmd_delay();
    run_cycle("R6", 1'b0, 1'b1, 3'b101, 1'b1, 3, 4);
    run_cycle("R6", 1'b1, 1'b0, 3'b001, 1'b1, 1, 2);
  endtask

  task automatic t_early_ready();
    run_cycle("R7", 1'b0, 1'b1, 3'b001, 1'b1, 6, 1);
    run_cycle("R7", 1'b1, 1'b0, 3'b110, 1'b1, 6, 1);
  endtask

  task automatic t_short_zero_wait();
    run_cycle("R8", 1'b0, 1'b1, 3'b010, 1'b1, 0, 0);
  endtask

  task automatic t_bus_wait();
    run_cycle("R9", 1'b1, 1'b0, 3'b110, 1'b1, 0, 0);
    run_cycle("R9", 1'b1, 1'b0, 3'b000, 1'b1, 0, 2);
  endtask

  task automatic t_bus_off();
    run_cycle("R10", 1'b1, 1'b1, 3'b101, 1'b1, 0, 1);
    run_cycle("R10", 1'b1, 1'b0, 3'b101, 1'b1, 0, 1);
  endtask

  task automatic t_short_gate();
    run_cycle("R11", 1'b0, 1'b0, 3'b110, 1'b1, 0, 1);
    run_cycle("R11", 1'b0, 1'b0, 3'b000, 1'b1, 0, 0);
  endtask

  initial begin
    t_reset();
    t_decode_all();
    t_halt();
    t_idle_codes();
    t_latched_sel();
    t_cmd_delay();
    t_early_ready();
    t_short_zero_wait();
    t_bus_wait();
    t_bus_off();
    t_short_gate();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete (R1..R13 not all reached), got hang expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule